// File: doc/BRIEF.md
# Reservation Monitor for Linked and Locked Atomic Sequences

This block sits beside a data cache and follows the atomic state of cache lines while memory operations complete. For each completed operation it receives an operation code, the line address, the identifier of the requester and whether the line's tag is present in the cache. A load-linked records a reservation for its line, tagged with the requester. A store-conditional succeeds only when that requester still holds the reservation. Ordinary write-class operations drop a reservation under a narrower condition. Each completion is answered one cycle later with a result word: 1 means success and 0 means failure.

The reservations live in a small table of slots. When the table is full, a new load-linked evicts the oldest reservation. Age is kept as a compact rank per slot, so removing an entry never leaves a gap in the ranking.

A second small state machine handles locked read-modify-write pairs. A locked read moves it from state FREE to state HELD and captures the line, which keeps the request queue for that address blocked. The HELD to FREE transition is taken only by a locked write to the same line. A locked read of a different line while in HELD raises a one-cycle error flag, and the existing block stays in place. A bypass input switches off all reservation handling. The lock machine keeps working under bypass.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no reservation is held, the lock machine is in FREE (`blk_active_o`=0), `rsp_valid_o`=0 and `blk_err_o`=0. A store-conditional issued straight after reset fails.
- R2: A completion presented with `op_valid_i`=1 at one clock edge sets `rsp_valid_o` for exactly the following cycle. `rsp_word_o` is then 1 for success and 0 for failure, and all bits above bit 0 are zero.
- R3: A load-linked (code 3) always reports success and reserves its line for the presenting requester. A later load-linked to a line that is already reserved takes over that reservation and makes it the newest.
- R4: A store-conditional (code 4) succeeds only if its line is reserved by the same requester identifier. It fails when the line is unreserved or is reserved by another requester.
- R5: Every store-conditional removes the reservation on its line, whether it succeeds or fails and whichever requester holds it.
- R6: A store (code 2), a plain read-modify-write (code 7), a locked read (code 5) or a locked write (code 6) reports success. It removes the reservation on its line only when `op_tag_hit_i`=1 and the line is reserved by the same requester; otherwise the reservation survives.
- R7: A load (code 0) and an instruction fetch (code 1) report success and leave every reservation unchanged.
- R8: The table holds SLOTS reservations. A load-linked fills a free slot when one exists. When all slots are valid, it replaces the slot whose reservation was set or refreshed longest ago. A removed slot does not disturb the relative age of the remaining slots.
- R9: With `bypass_i`=1 every operation reports success and no reservation is set, checked or removed.
- R10: A locked read (code 5) in FREE moves to HELD with `blk_active_o`=1 and `blk_line_o` set to its line. In HELD, only a locked write (code 6) to the same line returns to FREE. A locked write to another line leaves the block unchanged.
- R11: A locked read of a different line while in HELD pulses `blk_err_o` for one cycle and leaves `blk_active_o` and `blk_line_o` unchanged. A locked read of the held line raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_i | input | 1 | Disables all reservation handling |
| op_valid_i | input | 1 | A completed operation is presented this cycle |
| op_code_i | input | 3 | Operation code (0 load, 1 fetch, 2 store, 3 load-linked, 4 store-conditional, 5 locked read, 6 locked write, 7 read-modify-write) |
| op_line_i | input | LINE_W | Line address of the operation |
| op_req_i | input | REQ_W | Requester identifier |
| op_tag_hit_i | input | 1 | Line tag is present in the cache |
| rsp_valid_o | output | 1 | Result word is valid |
| rsp_word_o | output | WORD_W | 1 on success, 0 on failure |
| blk_active_o | output | 1 | A locked sequence holds its address blocked |
| blk_line_o | output | LINE_W | Line address being held |
| blk_err_o | output | 1 | One-cycle pulse: locked read of another line while blocked |

## Verification
The bench fills the table and adds one more load-linked to check that the oldest entry is evicted. It also refreshes a line before the overflow: a design that does not update age on refresh evicts the wrong line. After removing a middle-aged slot and refilling, it checks the victim again, because an age rank that is not compacted picks the wrong slot or wraps. It separates the two clearing rules by issuing writes with the tag absent and with a foreign requester, which a design that always clears would wrongly cancel. It checks that a failed store-conditional still removes the reservation, that bypass neither sets nor removes reservations, and that the lock machine ignores a locked write to a foreign line while flagging a locked read of one.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_FETCH = 3'd1,
        OP_STORE = 3'd2,
        OP_LINK  = 3'd3,
        OP_COND  = 3'd4,
        OP_LKRD  = 3'd5,
        OP_LKWR  = 3'd6,
        OP_RMW   = 3'd7
    } op_e;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lk_state_e;

endpackage

// File: rtl/rsv_slot_table.sv
module rsv_slot_table #(
    parameter int LINE_W = 26,
    parameter int REQ_W  = 4,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_i,
    input  logic              cond_i,
    input  logic              wr_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [REQ_W-1:0]  req_i,
    input  logic              tag_hit_i,
    output logic              cond_ok_o
);
    localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int AW = IW;
    localparam logic [AW:0] RANK_NEW  = SLOTS[AW:0];
    localparam logic [AW-1:0] RANK_OLD = AW'(SLOTS - 1);

    logic [SLOTS-1:0]  vld_q;
    logic [LINE_W-1:0] line_q [SLOTS];
    logic [REQ_W-1:0]  own_q  [SLOTS];
    logic [AW-1:0]     age_q  [SLOTS];

    logic [SLOTS-1:0] m_line;
    logic [SLOTS-1:0] m_own;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_match
            assign m_line[g] = vld_q[g] && (line_q[g] == line_i);
            assign m_own[g]  = m_line[g] && (own_q[g] == req_i);
        end
    endgenerate

    logic          any_line, any_own, any_free;
    logic [IW-1:0] line_idx, free_idx, old_idx;
    logic [IW-1:0] alloc_idx;
    logic [AW:0]   alloc_rank;
    logic          clr_en;

    always_comb begin
        line_idx = '0;
        free_idx = '0;
        old_idx  = '0;
        any_free = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (m_line[i]) line_idx = IW'(i);
            if (!vld_q[i]) begin
                free_idx = IW'(i);
                any_free = 1'b1;
            end
            if (vld_q[i] && age_q[i] == RANK_OLD) old_idx = IW'(i);
        end
        any_line = |m_line;
        any_own  = |m_own;
        if (any_line) begin
            alloc_idx  = line_idx;
            alloc_rank = {1'b0, age_q[line_idx]};
        end else if (any_free) begin
            alloc_idx  = free_idx;
            alloc_rank = RANK_NEW;
        end else begin
            alloc_idx  = old_idx;
            alloc_rank = {1'b0, RANK_OLD};
        end
        clr_en = cond_i ? any_line : (wr_i && tag_hit_i && any_own);
    end

    assign cond_ok_o = any_own;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int j = 0; j < SLOTS; j++) begin
                line_q[j] <= '0;
                own_q[j]  <= '0;
                age_q[j]  <= '0;
            end
        end else if (link_i) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (IW'(j) == alloc_idx) begin
                    vld_q[j]  <= 1'b1;
                    line_q[j] <= line_i;
                    own_q[j]  <= req_i;
                    age_q[j]  <= '0;
                end else if (vld_q[j] && ({1'b0, age_q[j]} < alloc_rank)) begin
                    age_q[j] <= age_q[j] + 1'b1;
                end
            end
        end else if (clr_en) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (IW'(j) == line_idx) begin
                    vld_q[j] <= 1'b0;
                end else if (vld_q[j] && (age_q[j] > age_q[line_idx])) begin
                    age_q[j] <= age_q[j] - 1'b1;
                end
            end
        end
    end

    AST_LINK_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
        link_i |=> vld_q[$past(alloc_idx)]); // R3

    AST_COND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i |=> ((vld_q & $past(m_line)) == '0)); // R5

    AST_ONE_SLOT_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_line)); // R8

endmodule

// File: rtl/rsv_lock_fsm.sv
module rsv_lock_fsm
    import rsv_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkrd_i,
    input  logic              lkwr_i,
    input  logic [LINE_W-1:0] line_i,
    output logic              blk_active_o,
    output logic [LINE_W-1:0] blk_line_o,
    output logic              blk_err_o
);
    lk_state_e         state_q, state_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              err_q, err_d;

    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        err_d   = 1'b0;
        unique case (state_q)
            LK_FREE: begin
                if (lkrd_i) begin
                    state_d = LK_HELD;
                    line_d  = line_i;
                end
            end
            LK_HELD: begin
                if (lkwr_i && line_i == line_q) begin
                    state_d = LK_FREE;
                end else if (lkrd_i && line_i != line_q) begin
                    err_d = 1'b1;
                end
            end
            default: state_d = LK_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_FREE;
            line_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        blk_active_o = (state_q == LK_HELD);
        blk_line_o   = line_q;
        blk_err_o    = err_q;
    end

    AST_ERR_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        blk_err_o |-> blk_active_o); // R11

    AST_ERR_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_err_o |-> $stable(blk_line_o)); // R11

    AST_MATCH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_HELD && lkwr_i && line_i == line_q) |=> !blk_active_o); // R10

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int REQ_W  = 4,
    parameter int SLOTS  = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass_i,
    input  logic              op_valid_i,
    input  logic [2:0]        op_code_i,
    input  logic [LINE_W-1:0] op_line_i,
    input  logic [REQ_W-1:0]  op_req_i,
    input  logic              op_tag_hit_i,
    output logic              rsp_valid_o,
    output logic [WORD_W-1:0] rsp_word_o,
    output logic              blk_active_o,
    output logic [LINE_W-1:0] blk_line_o,
    output logic              blk_err_o
);
    op_e  op;
    logic rsv_on;
    logic do_link, do_cond, do_wr, do_lkrd, do_lkwr;
    logic cond_ok, ok_d;
    logic rsp_valid_q, rsp_ok_q;

    assign op     = op_e'(op_code_i);
    assign rsv_on = op_valid_i && !bypass_i;

    always_comb begin
        do_link = 1'b0;
        do_cond = 1'b0;
        do_wr   = 1'b0;
        unique case (op)
            OP_LINK:                         do_link = rsv_on;
            OP_COND:                         do_cond = rsv_on;
            OP_STORE, OP_RMW, OP_LKRD, OP_LKWR: do_wr = rsv_on;
            default: ;
        endcase
    end

    assign do_lkrd = op_valid_i && (op == OP_LKRD);
    assign do_lkwr = op_valid_i && (op == OP_LKWR);

    rsv_slot_table #(
        .LINE_W (LINE_W),
        .REQ_W  (REQ_W),
        .SLOTS  (SLOTS)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_i    (do_link),
        .cond_i    (do_cond),
        .wr_i      (do_wr),
        .line_i    (op_line_i),
        .req_i     (op_req_i),
        .tag_hit_i (op_tag_hit_i),
        .cond_ok_o (cond_ok)
    );

    rsv_lock_fsm #(
        .LINE_W (LINE_W)
    ) u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .lkrd_i       (do_lkrd),
        .lkwr_i       (do_lkwr),
        .line_i       (op_line_i),
        .blk_active_o (blk_active_o),
        .blk_line_o   (blk_line_o),
        .blk_err_o    (blk_err_o)
    );

    assign ok_d = do_cond ? cond_ok : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_ok_q    <= 1'b0;
        end else begin
            rsp_valid_q <= op_valid_i;
            rsp_ok_q    <= op_valid_i && ok_d;
        end
    end

    always_comb begin
        rsp_valid_o = rsp_valid_q;
        rsp_word_o  = {{(WORD_W-1){1'b0}}, rsp_ok_q};
    end

    AST_RSP_FOLLOWS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(op_valid_i)); // R2

    AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_word_o[WORD_W-1:1] == '0); // R2

    AST_BYPASS_SUCCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(bypass_i)) |-> rsp_word_o[0]); // R9

    AST_FAIL_ONLY_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_word_o[0]) |-> ($past(op_code_i) == OP_COND)); // R4

endmodule

// File: tb/tb_rsv_monitor.sv
module tb_rsv_monitor;
    localparam int LINE_W = 26;
    localparam int REQ_W  = 4;
    localparam int SLOTS  = 4;
    localparam int WORD_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bypass_i;
    logic              op_valid_i;
    logic [2:0]        op_code_i;
    logic [LINE_W-1:0] op_line_i;
    logic [REQ_W-1:0]  op_req_i;
    logic              op_tag_hit_i;
    logic              rsp_valid_o;
    logic [WORD_W-1:0] rsp_word_o;
    logic              blk_active_o;
    logic [LINE_W-1:0] blk_line_o;
    logic              blk_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    rsv_monitor #(.LINE_W(LINE_W), .REQ_W(REQ_W), .SLOTS(SLOTS), .WORD_W(WORD_W)) dut (
        .clk(clk), .rst_n(rst_n), .bypass_i(bypass_i), .op_valid_i(op_valid_i),
        .op_code_i(op_code_i), .op_line_i(op_line_i), .op_req_i(op_req_i),
        .op_tag_hit_i(op_tag_hit_i), .rsp_valid_o(rsp_valid_o), .rsp_word_o(rsp_word_o),
        .blk_active_o(blk_active_o), .blk_line_o(blk_line_o), .blk_err_o(blk_err_o)
    );

    localparam logic [2:0] C_LOAD = 3'd0, C_FETCH = 3'd1, C_STORE = 3'd2, C_LINK = 3'd3,
                           C_COND = 3'd4, C_LKRD = 3'd5, C_LKWR = 3'd6, C_RMW = 3'd7;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // present one operation, return the word seen in the following cycle
    task automatic op(input logic [2:0] code, input logic [LINE_W-1:0] line,
                      input logic [REQ_W-1:0] req, input logic hit,
                      output logic [WORD_W-1:0] word);
        @(negedge clk);
        op_valid_i   = 1'b1;
        op_code_i    = code;
        op_line_i    = line;
        op_req_i     = req;
        op_tag_hit_i = hit;
        @(negedge clk);
        op_valid_i   = 1'b0;
        if (rsp_valid_o !== 1'b1) begin
            n_chk++; n_fail++;
            $display("FAIL R2 rsp_valid actual=%0b expected=1", rsp_valid_o);
        end
        word = rsp_word_o;
    endtask

    task automatic t_reset();
        logic [WORD_W-1:0] w;
        rst_n = 1'b0; bypass_i = 1'b0; op_valid_i = 1'b0;
        op_code_i = '0; op_line_i = '0; op_req_i = '0; op_tag_hit_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid", rsp_valid_o, 0);
        check("R1 blk_active", blk_active_o, 0);
        check("R1 blk_err", blk_err_o, 0);
        op(C_COND, 26'h10, 4'd1, 1'b1, w);
        check("R1 cond after reset fails", w, 0);
        @(negedge clk);
        check("R2 rsp_valid single cycle", rsp_valid_o, 0);
    endtask

    task automatic t_basic();
        logic [WORD_W-1:0] w;
        op(C_LINK, 26'h20, 4'd1, 1'b1, w);
        check("R3 link succeeds", w, 1);
        op(C_COND, 26'h20, 4'd1, 1'b1, w);
        check("R4 cond same requester ok (word=1)", w, 1);
        op(C_COND, 26'h20, 4'd1, 1'b1, w);
        check("R5 second cond fails after clear", w, 0);
    endtask

    task automatic t_requester();
        logic [WORD_W-1:0] w;
        op(C_LINK, 26'h30, 4'd1, 1'b1, w);
        op(C_COND, 26'h30, 4'd2, 1'b1, w);
        check("R4 cond other requester fails", w, 0);
        op(C_COND, 26'h30, 4'd1, 1'b1, w);
        check("R5 failed cond still cleared", w, 0);
        op(C_LINK, 26'h31, 4'd1, 1'b1, w);
        op(C_LINK, 26'h31, 4'd3, 1'b1, w);
        op(C_COND, 26'h31, 4'd3, 1'b1, w);
        check("R3 relink takes over owner", w, 1);
    endtask

    task automatic t_writes();
        logic [WORD_W-1:0] w;
        op(C_LINK, 26'h40, 4'd1, 1'b1, w);
        op(C_STORE, 26'h40, 4'd1, 1'b0, w);
        check("R6 store reports success", w, 1);
        op(C_COND, 26'h40, 4'd1, 1'b1, w);
        check("R6 store without tag keeps reservation", w, 1);
        op(C_LINK, 26'h41, 4'd1, 1'b1, w);
        op(C_RMW, 26'h41, 4'd2, 1'b1, w);
        op(C_COND, 26'h41, 4'd1, 1'b1, w);
        check("R6 foreign write keeps reservation", w, 1);
        op(C_LINK, 26'h42, 4'd1, 1'b1, w);
        op(C_STORE, 26'h42, 4'd1, 1'b1, w);
        op(C_COND, 26'h42, 4'd1, 1'b1, w);
        check("R6 own write with tag clears", w, 0);
    endtask

    task automatic t_loads();
        logic [WORD_W-1:0] w;
        op(C_LINK, 26'h50, 4'd2, 1'b1, w);
        op(C_LOAD, 26'h50, 4'd2, 1'b1, w);
        check("R7 load success", w, 1);
        op(C_FETCH, 26'h50, 4'd2, 1'b1, w);
        check("R7 fetch success", w, 1);
        op(C_COND, 26'h50, 4'd2, 1'b1, w);
        check("R7 reservation untouched by load/fetch", w, 1);
    endtask

    task automatic t_replace();
        logic [WORD_W-1:0] w;
        op(C_LINK, 26'h60, 4'd1, 1'b1, w);
        op(C_LINK, 26'h61, 4'd1, 1'b1, w);
        op(C_LINK, 26'h62, 4'd1, 1'b1, w);
        op(C_LINK, 26'h63, 4'd1, 1'b1, w);
        op(C_LINK, 26'h60, 4'd1, 1'b1, w);   // refresh: 0x61 now oldest
        op(C_LINK, 26'h64, 4'd1, 1'b1, w);   // evicts 0x61
        op(C_COND, 26'h61, 4'd1, 1'b1, w);
        check("R8 oldest evicted", w, 0);
        op(C_COND, 26'h60, 4'd1, 1'b1, w);
        check("R8 refreshed line kept", w, 1);
        op(C_COND, 26'h62, 4'd1, 1'b1, w);
        check("R8 middle line kept", w, 1);
        op(C_COND, 26'h63, 4'd1, 1'b1, w);
        op(C_COND, 26'h64, 4'd1, 1'b1, w);
        check("R8 newest line kept", w, 1);
    endtask

    task automatic t_compact();
        logic [WORD_W-1:0] w;
        op(C_LINK, 26'h70, 4'd1, 1'b1, w);
        op(C_LINK, 26'h71, 4'd1, 1'b1, w);
        op(C_LINK, 26'h72, 4'd1, 1'b1, w);
        op(C_COND, 26'h71, 4'd1, 1'b1, w);   // remove middle
        op(C_LINK, 26'h73, 4'd1, 1'b1, w);
        op(C_LINK, 26'h74, 4'd1, 1'b1, w);
        op(C_LINK, 26'h75, 4'd1, 1'b1, w);   // evicts 0x70
        op(C_COND, 26'h70, 4'd1, 1'b1, w);
        check("R8 victim after removal", w, 0);
        op(C_COND, 26'h72, 4'd1, 1'b1, w);
        check("R8 survivor after removal", w, 1);
        op(C_COND, 26'h73, 4'd1, 1'b1, w);
        op(C_COND, 26'h74, 4'd1, 1'b1, w);
        op(C_COND, 26'h75, 4'd1, 1'b1, w);
        check("R8 newest after removal", w, 1);
    endtask

    task automatic t_bypass();
        logic [WORD_W-1:0] w;
        bypass_i = 1'b1;
        op(C_COND, 26'h80, 4'd1, 1'b1, w);
        check("R9 cond under bypass ok", w, 1);
        op(C_LINK, 26'h81, 4'd1, 1'b1, w);
        bypass_i = 1'b0;
        op(C_COND, 26'h81, 4'd1, 1'b1, w);
        check("R9 link under bypass sets nothing", w, 0);
        op(C_LINK, 26'h82, 4'd1, 1'b1, w);
        bypass_i = 1'b1;
        op(C_COND, 26'h82, 4'd1, 1'b1, w);
        op(C_STORE, 26'h82, 4'd1, 1'b1, w);
        bypass_i = 1'b0;
        op(C_COND, 26'h82, 4'd1, 1'b1, w);
        check("R9 bypass removes nothing", w, 1);
    endtask

    task automatic t_lock();
        logic [WORD_W-1:0] w;
        op(C_LKRD, 26'h90, 4'd1, 1'b1, w);
        check("R10 held after locked read", blk_active_o, 1);
        check("R10 held line", blk_line_o, 26'h90);
        op(C_LKRD, 26'h91, 4'd1, 1'b1, w);
        check("R11 error pulse", blk_err_o, 1);
        check("R11 line kept", blk_line_o, 26'h90);
        @(negedge clk);
        check("R11 error is one cycle", blk_err_o, 0);
        op(C_LKRD, 26'h90, 4'd1, 1'b1, w);
        check("R11 same line no error", blk_err_o, 0);
        op(C_LKWR, 26'h92, 4'd1, 1'b1, w);
        check("R10 foreign locked write ignored", blk_active_o, 1);
        op(C_LKWR, 26'h90, 4'd1, 1'b1, w);
        check("R10 matching write releases", blk_active_o, 0);
        bypass_i = 1'b1;
        op(C_LKRD, 26'h93, 4'd1, 1'b1, w);
        check("R10 lock works under bypass", blk_active_o, 1);
        op(C_LKWR, 26'h93, 4'd1, 1'b1, w);
        bypass_i = 1'b0;
        check("R10 release under bypass", blk_active_o, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_requester();
        t_writes();
        t_loads();
        t_replace();
        t_compact();
        t_bypass();
        t_lock();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule